// File: doc/BRIEF.md
# Memory-Card Slot Status and Board Identification Registers

This block is a small word-indexed register file. It returns a fixed board identity word and a fixed address-decode word, and it holds the interrupt status for a memory-card slot. Two asynchronous signals come from the slot: a write-protect level and a card-inserted indication. The block passes both through a synchronizer before it uses them.

The write-protect state appears in the status word as a live level. A card insertion is handled differently. It is captured by a two-state event machine, and the capture stays after the input drops. The captured state drives the interrupt line until software writes a one to the matching status bit.

The event machine has two states. `EV_IDLE` means no insertion is pending. `EV_PENDING` means an insertion was seen and has not yet been acknowledged. The transition *detect* goes from `EV_IDLE` to `EV_PENDING` when the synchronized card-inserted signal is high. The transition *acknowledge* goes from `EV_PENDING` to `EV_IDLE` on a status write with bit 3 set, but only while the synchronized card-inserted signal is low. Otherwise the machine *holds* its state.

Reads are combinational from `reg_addr`. Writes take effect at the rising clock edge while `reg_wr` is high.

Top module: `cds_card_status`

## Requirements
- R1: Index 0 reads 0x41034003, index 1 reads 0x00000000 and index 3 reads 0x00000011.
- R2: Status (index 2) bit 0 equals the write-protect input, delayed by two clock edges, and no write changes it.
- R3: Status bit 3 is set three edges after the card-inserted input is sampled high, even for a one-cycle pulse. It stays set after the input falls.
- R4: A write to index 2 clears bit 3 only when `reg_wdata[3]` is 1. A write with `reg_wdata[3]` equal to 0 leaves it set.
- R5: `card_irq` always equals status bit 3.
- R6: Writes to indices 1 and 3 have no effect. All indices other than 0 to 3 read zero, and writes to them have no effect. Status bits 1, 2 and 4 to 31 read zero.
- R7: When a clearing write coincides with a high synchronized card-inserted signal, bit 3 stays set.
- R8: After reset, status reads zero and `card_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Word index for both read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| wp_level | input | 1 | Asynchronous write-protect level from the slot |
| card_in | input | 1 | Asynchronous card-inserted indication |
| card_irq | output | 1 | Interrupt, high while an insertion is pending |

## Verification
The hardest case to reach is an acknowledge write landing in the same cycle as a high synchronized card-inserted signal. The synchronizer adds a two-edge delay, so this is not the cycle in which the input rises. The bench therefore holds `card_in` high across several cycles and issues the clearing write inside that window. It then drops `card_in` and shows that a later write does clear the bit. Long pseudo-random phases then mix pulses, writes to every index and write-protect toggles. A behavioural model is compared against every output on every clock.

// File: rtl/cds_pkg.sv
package cds_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_ID   = 0;
    localparam int IDX_FLSH = 1;
    localparam int IDX_STAT = 2;
    localparam int IDX_DEC  = 3;
    localparam int BIT_WP   = 0;
    localparam int BIT_CARD = 3;
    localparam logic [DATA_W-1:0] BOARD_ID    = 32'h4103_4003;
    localparam logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011;

    typedef enum logic {
        EV_IDLE,
        EV_PENDING
    } ev_state_t;
endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cds_event_fsm.sv
module cds_event_fsm
    import cds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic detect_i,
    input  logic ack_i,
    output logic pending_o
);
    ev_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (detect_i) state_d = EV_PENDING;
            EV_PENDING: if (ack_i && !detect_i) state_d = EV_IDLE;
            default:    state_d = EV_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q == EV_PENDING);
    end

    assert_detect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        detect_i |=> state_q == EV_PENDING);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_PENDING && !ack_i) |=> state_q == EV_PENDING);
    assert_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EV_PENDING && ack_i && !detect_i) |=> state_q == EV_IDLE);
endmodule

// File: rtl/cds_read_mux.sv
module cds_read_mux
    import cds_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_i,
    input  logic              pend_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[BIT_WP]   = wp_i;
        status_word[BIT_CARD] = pend_i;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(IDX_ID):   data_o = BOARD_ID;
            ADDR_W'(IDX_FLSH): data_o = '0;
            ADDR_W'(IDX_STAT): data_o = status_word;
            ADDR_W'(IDX_DEC):  data_o = DECODE_WORD;
            default:           data_o = '0;
        endcase
    end
endmodule

// File: rtl/cds_card_status.sv
module cds_card_status
    import cds_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              wp_level,
    input  logic              card_in,
    output logic              card_irq
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw_in, synced;
    logic            wp_s, card_s, ack, pending;
    logic            unused_wdata;

    assign raw_in = {card_in, wp_level};
    assign unused_wdata = ^reg_wdata;

    cds_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_in),
        .sync_o (synced)
    );

    assign wp_s   = synced[0];
    assign card_s = synced[1];
    assign ack    = reg_wr && (reg_addr == ADDR_W'(IDX_STAT)) && reg_wdata[BIT_CARD];

    cds_event_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .detect_i (card_s),
        .ack_i    (ack),
        .pending_o(pending)
    );

    cds_read_mux #(.ADDR_W(ADDR_W)) u_mux (
        .addr_i(reg_addr),
        .wp_i  (wp_s),
        .pend_i(pending),
        .data_o(reg_rdata)
    );

    assign card_irq = pending;

    assert_irq_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(IDX_STAT)) |-> reg_rdata[BIT_CARD] == card_irq);
endmodule

// File: tb/cds_card_status_tb.sv
module cds_card_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wp_level = 1'b0;
    logic        card_in = 1'b0;
    logic        card_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit m_wp1, m_wp2, m_cd1, m_cd2, m_pend;

    always #4 clk = ~clk;

    cds_card_status u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wp_level(wp_level), .card_in(card_in), .card_irq(card_irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wp1 = 0; m_wp2 = 0; m_cd1 = 0; m_cd2 = 0; m_pend = 0;
        end else begin
            if (m_cd2) m_pend = 1;
            else if (reg_wr && reg_addr == 4'd2 && reg_wdata[3]) m_pend = 0;
            m_wp2 = m_wp1; m_wp1 = wp_level;
            m_cd2 = m_cd1; m_cd1 = card_in;
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return 32'h4103_4003;
            4'd2: return {28'd0, m_pend, 2'b00, m_wp2};
            4'd3: return 32'h0000_0011;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check({tag, " rdata"}, reg_rdata, model_read(reg_addr));
        check("R5 irq", {31'd0, card_irq}, {31'd0, m_pend});
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic wp, input logic cd, input string tag);
        reg_wr = wr; reg_addr = a; reg_wdata = d; wp_level = wp; card_in = cd;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 4'd2, 0, 0, 0, "R8 reset status");
        check("R8 reset irq", {31'd0, card_irq}, 32'd0);
        step(0, 4'd0, 0, 0, 0, "R1 id");
        step(0, 4'd1, 0, 0, 0, "R1 flash");
        step(0, 4'd3, 0, 0, 0, "R1 decode");
        // one-cycle insertion pulse
        step(0, 4'd2, 0, 0, 1, "R3 pulse");
        for (int i = 0; i < 4; i++) step(0, 4'd2, 0, 0, 0, "R3 sticky");
        check("R3 set", reg_rdata, 32'h8);
        step(1, 4'd2, 32'hFFFF_FFF7, 0, 0, "R4 no-clear");
        check("R4 kept", reg_rdata, 32'h8);
        step(1, 4'd1, 32'hFFFF_FFFF, 0, 0, "R6 write idx1");
        step(1, 4'd3, 32'hFFFF_FFFF, 0, 0, "R6 write idx3");
        step(1, 4'd9, 32'hFFFF_FFFF, 0, 0, "R6 write idx9");
        step(0, 4'd2, 0, 0, 0, "R6 status intact");
        check("R6 still set", reg_rdata, 32'h8);
        step(1, 4'd2, 32'h8, 0, 0, "R4 clear");
        check("R4 cleared", reg_rdata, 32'h0);
        // write-protect live level, unaffected by writes
        step(0, 4'd2, 0, 1, 0, "R2 wp rise");
        step(0, 4'd2, 0, 1, 0, "R2 wp sync");
        step(1, 4'd2, 32'h0, 1, 0, "R2 write zero");
        check("R2 wp held", reg_rdata, 32'h1);
        step(0, 4'd2, 0, 0, 0, "R2 wp fall");
        step(0, 4'd2, 0, 0, 0, "R2 wp low");
        check("R2 wp low", reg_rdata, 32'h0);
        // set wins over simultaneous clear
        for (int i = 0; i < 4; i++) step(0, 4'd2, 0, 0, 1, "R7 hold high");
        step(1, 4'd2, 32'h8, 0, 1, "R7 clear vs set");
        check("R7 set wins", reg_rdata, 32'h8);
        for (int i = 0; i < 3; i++) step(0, 4'd2, 0, 0, 0, "R7 drain");
        step(1, 4'd2, 32'h8, 0, 0, "R7 later clear");
        check("R7 cleared", reg_rdata, 32'h0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[7:4], {$urandom} | {28'd0, r[8], 3'd0},
                 (r[12:9] == 0) ? ~wp_level : wp_level,
                 r[15:13] == 0, "R3 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule